// File: doc/BRIEF.md
# UART Receive Holding Queue

This block sits between a UART deserializer and the register interface of the UART. It holds up to four received bytes in arrival order. The deserializer delivers data bytes and line-break events. A break event stores a zero byte and also raises a one-cycle break-change pulse for the interrupt logic. On the register side, a read of the receive buffer register takes the oldest byte and removes it from the queue.

Two status bits are kept as registered level flags and are not decoded from pointers. The receive-ready flag means at least one byte is waiting. The full flag means four bytes are held. A can-accept output tells the deserializer whether the receiver is enabled and has room. The reset-receiver command drives a synchronous clear input that empties the queue. A data byte offered while the queue is full is discarded, and a one-cycle overflow pulse is sent to the status logic.

Top module: `rx_hold_queue`

## Requirements
- R1: After reset, rxReady, fifoFull, breakPulse and overflowPulse are low and readData is 0x00.
- R2: The queue holds four bytes. Every accepted push sets rxReady. fifoFull goes high in the cycle after the fourth byte is stored.
- R3: readData always shows the oldest stored byte. Bytes leave in arrival order. A cycle with popReq high removes the oldest byte and clears fifoFull. rxReady falls only when the queue becomes empty.
- R4: A breakEvent makes breakPulse high for exactly the following cycle and stores 0x00. If the queue is full, the 0x00 replaces the newest byte and the count stays at four. A data push in the same cycle as a break is discarded and raises no overflow pulse.
- R5: canAccept is high exactly when rxEnable is high and fifoFull is low. It follows rxEnable within the same cycle.
- R6: clearRx empties the queue and clears rxReady and fifoFull on the next edge. A push or pop in the same cycle has no effect.
- R7: A pop while the queue is empty shows readData 0x00 and changes no flag and no stored content.
- R8: A pop and a push in the same cycle apply the pop first and then the push. This is true even when the queue is full, so the count stays the same.
- R9: A data push while the queue is full, with no pop in that cycle, is dropped. overflowPulse is then high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enabled |
| pushValid | input | 1 | Deserializer offers a data byte |
| pushData | input | 8 | Offered data byte |
| breakEvent | input | 1 | Line break detected (one cycle) |
| popReq | input | 1 | Receive buffer register read strobe |
| clearRx | input | 1 | Reset-receiver command, synchronous clear |
| readData | output | 8 | Oldest byte, 0x00 when empty |
| canAccept | output | 1 | Deserializer may deliver a byte |
| rxReady | output | 1 | At least one byte held |
| fifoFull | output | 1 | Four bytes held |
| breakPulse | output | 1 | Break-change pulse to interrupt logic |
| overflowPulse | output | 1 | Data push dropped because the queue was full |

## Verification
Bugs in the read or write pointers show up at readData right away, as a wrong oldest byte, and in the same cycle as the pop that exposes them. A wrong count shows up on the cycle after the faulty update. It appears as a rxReady or fifoFull level that disagrees with the number of bytes the bench holds, or as an overflow pulse at the wrong time. A fault in the break overwrite path stays hidden until the queue has drained down to the replaced slot, so the bench drains the queue after every full-queue break.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic clearAll;   // reset both pointers
    logic popEn;      // advance read pointer
    logic pushEn;     // store a byte
    logic overwrite;  // store into newest slot instead of next free slot
    logic pushZero;   // stored byte is 0x00 (break)
  } rxqStrobes_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rxq_pkg::rxqStrobes_t strobes,
  input  logic [DATA_W-1:0]   pushData,
  input  logic                notEmpty,
  output logic [DATA_W-1:0]   readData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr, wrAddr, newestPtr;
  logic [DATA_W-1:0] wrData;

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    newestPtr = (wrPtr == '0) ? LAST : wrPtr - PTR_W'(1);
    wrAddr    = strobes.overwrite ? newestPtr : wrPtr;
    wrData    = strobes.pushZero ? '0 : pushData;
    readData  = notEmpty ? slots[rdPtr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (strobes.clearAll) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strobes.popEn) rdPtr <= incPtr(rdPtr);
      if (strobes.pushEn && !strobes.overwrite) wrPtr <= incPtr(wrPtr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots[g] <= '0;
      else if (strobes.pushEn && !strobes.clearAll && wrAddr == PTR_W'(g))
        slots[g] <= wrData;
    end
  end

  // R6
  clear_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearAll |=> (rdPtr == wrPtr));

  // R7
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.popEn && !strobes.clearAll) |-> notEmpty);
endmodule

// File: rtl/rxq_control.sv
module rxq_control #(
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pushValid,
  input  logic                 breakEvent,
  input  logic                 popReq,
  input  logic                 clearRx,
  output rxq_pkg::rxqStrobes_t strobes,
  output logic                 rxReady,
  output logic                 fifoFull,
  output logic                 breakPulse,
  output logic                 overflowPulse
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count, cntAfterPop, nextCount;
  logic             popEff, pushEff, dropData;

  always_comb begin
    strobes     = '0;
    dropData    = 1'b0;
    pushEff     = 1'b0;
    popEff      = popReq && rxReady && !clearRx;
    cntAfterPop = count - CNT_W'(popEff);
    if (clearRx) begin
      strobes.clearAll = 1'b1;
      nextCount        = '0;
    end else begin
      strobes.popEn = popEff;
      if (breakEvent) begin
        pushEff           = 1'b1;
        strobes.pushZero  = 1'b1;
        strobes.overwrite = (cntAfterPop == FULL_CNT);
      end else if (pushValid) begin
        if (cntAfterPop == FULL_CNT) dropData = 1'b1;
        else                         pushEff  = 1'b1;
      end
      strobes.pushEn = pushEff;
      nextCount = cntAfterPop + CNT_W'(pushEff && !strobes.overwrite);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count         <= '0;
      rxReady       <= 1'b0;
      fifoFull      <= 1'b0;
      breakPulse    <= 1'b0;
      overflowPulse <= 1'b0;
    end else begin
      count         <= nextCount;
      rxReady       <= (nextCount != '0);
      fifoFull      <= (nextCount == FULL_CNT);
      breakPulse    <= breakEvent;
      overflowPulse <= dropData;
    end
  end

  // R2
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoFull == (count == FULL_CNT));

  // R3
  ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxReady == (count != '0));

  // R4
  break_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    breakEvent |=> breakPulse);

  // R6
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearRx |=> (!rxReady && !fifoFull));

  // R7
  empty_pop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popReq && !rxReady && !pushValid && !breakEvent && !clearRx) |=> $stable(count));

  // R9
  ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflowPulse |-> ($past(fifoFull) && !$past(popReq) && !$past(breakEvent)));
endmodule

// File: rtl/rx_hold_queue.sv
module rx_hold_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              breakEvent,
  input  logic              popReq,
  input  logic              clearRx,
  output logic [DATA_W-1:0] readData,
  output logic              canAccept,
  output logic              rxReady,
  output logic              fifoFull,
  output logic              breakPulse,
  output logic              overflowPulse
);
  rxq_pkg::rxqStrobes_t strobes;

  rxq_control #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .breakEvent(breakEvent),
    .popReq(popReq), .clearRx(clearRx), .strobes(strobes), .rxReady(rxReady),
    .fifoFull(fifoFull), .breakPulse(breakPulse), .overflowPulse(overflowPulse)
  );

  rxq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pushData(pushData),
    .notEmpty(rxReady), .readData(readData)
  );

  assign canAccept = rxEnable && !fifoFull;

  // R5
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && canAccept && !breakEvent && !clearRx && !popReq) |=> rxReady);
endmodule

// File: tb/test_rx_hold_queue.sv
`timescale 1ns/1ps
module test_rx_hold_queue;
  logic clk = 0, rst_n = 0;
  logic rxEnable = 0, pushValid = 0, breakEvent = 0, popReq = 0, clearRx = 0;
  logic [7:0] pushData = 0, readData;
  logic canAccept, rxReady, fifoFull, breakPulse, overflowPulse;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] mq[$];
  bit expBrk = 0, expOvf = 0;

  always #10 clk = ~clk;

  rx_hold_queue i_rx_hold_queue (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .pushValid(pushValid),
    .pushData(pushData), .breakEvent(breakEvent), .popReq(popReq), .clearRx(clearRx),
    .readData(readData), .canAccept(canAccept), .rxReady(rxReady), .fifoFull(fifoFull),
    .breakPulse(breakPulse), .overflowPulse(overflowPulse)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expHead();
    return (mq.size() > 0) ? mq[0] : 8'h00;
  endfunction

  // Independent reference update, pop first then push.
  function automatic void modelStep(bit psh, logic [7:0] d, bit brk, bit pop, bit clr);
    expBrk = brk;
    expOvf = 0;
    if (clr) begin
      mq.delete();
      return;
    end
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (brk) begin
      if (mq.size() == 4) mq[3] = 8'h00;
      else mq.push_back(8'h00);
    end else if (psh) begin
      if (mq.size() == 4) expOvf = 1;
      else mq.push_back(d);
    end
  endfunction

  task automatic checkState(input string tag);
    chk(tag, "rxReady", rxReady, mq.size() > 0);
    chk(tag, "fifoFull", fifoFull, mq.size() == 4);
    chk(tag, "canAccept", canAccept, rxEnable && mq.size() != 4);
    chk(tag, "breakPulse", breakPulse, expBrk);
    chk(tag, "overflowPulse", overflowPulse, expOvf);
    chk(tag, "readData", readData, expHead());
  endtask

  // Called at a falling edge; drives one cycle of stimulus.
  task automatic step(input string tag, input bit psh, input logic [7:0] d,
                      input bit brk, input bit pop, input bit clr);
    pushValid = psh; pushData = d; breakEvent = brk; popReq = pop; clearRx = clr;
    #1;
    if (pop) chk(tag, "readData at pop", readData, expHead());
    @(posedge clk);
    modelStep(psh, d, brk, pop, clr);
    @(negedge clk);
    pushValid = 0; breakEvent = 0; popReq = 0; clearRx = 0;
    #1;
    checkState(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "rxReady", rxReady, 0);
    chk("R1", "fifoFull", fifoFull, 0);
    chk("R1", "breakPulse", breakPulse, 0);
    chk("R1", "overflowPulse", overflowPulse, 0);
    chk("R1", "readData", readData, 8'h00);
    rst_n = 1;
    @(negedge clk);
    // R5 canAccept follows rxEnable combinationally
    chk("R5", "canAccept disabled", canAccept, 0);
    rxEnable = 1; #1;
    chk("R5", "canAccept enabled", canAccept, 1);
    // R2 fill to four
    step("R2", 1, 8'h11, 0, 0, 0);
    step("R2", 1, 8'h22, 0, 0, 0);
    step("R2", 1, 8'h33, 0, 0, 0);
    chk("R2", "not full at three", fifoFull, 0);
    step("R2", 1, 8'h44, 0, 0, 0);
    chk("R2", "full at four", fifoFull, 1);
    chk("R5", "canAccept when full", canAccept, 0);
    // R9 push while full dropped
    step("R9", 1, 8'h55, 0, 0, 0);
    chk("R9", "overflow pulse", overflowPulse, 1);
    @(negedge clk); #1;
    chk("R9", "overflow single cycle", overflowPulse, 0);
    chk("R9", "head intact", readData, 8'h11);
    // R3 pop oldest, full clears
    step("R3", 0, 0, 0, 1, 0);
    chk("R3", "full cleared", fifoFull, 0);
    chk("R3", "next oldest", readData, 8'h22);
    step("R4", 1, 8'h66, 0, 0, 0);
    // R4 break on full queue overwrites newest
    step("R4", 1, 8'h77, 1, 0, 0);
    chk("R4", "break pulse", breakPulse, 1);
    chk("R4", "still full", fifoFull, 1);
    chk("R4", "no overflow on break", overflowPulse, 0);
    step("R3", 0, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 1, 0);
    chk("R4", "zero replaced newest", readData, 8'h00);
    chk("R3", "ready with one left", rxReady, 1);
    step("R3", 0, 0, 0, 1, 0);
    chk("R3", "ready clears when empty", rxReady, 0);
    // R7 empty read
    step("R7", 0, 0, 0, 1, 0);
    chk("R7", "empty read zero", readData, 8'h00);
    // R4 break on empty queue
    step("R4", 0, 0, 1, 0, 0);
    chk("R4", "break stores zero", rxReady, 1);
    step("R3", 0, 0, 0, 1, 0);
    // R8 pop and push together
    step("R8", 1, 8'hA1, 0, 0, 0);
    step("R8", 1, 8'hB2, 0, 0, 0);
    step("R8", 1, 8'hC3, 0, 1, 0);
    chk("R8", "head after pop+push", readData, 8'hB2);
    step("R8", 1, 8'hD4, 0, 0, 0);
    step("R8", 1, 8'hE5, 0, 0, 0);
    step("R8", 1, 8'hF6, 0, 1, 0);
    chk("R8", "full kept on pop+push", fifoFull, 1);
    chk("R8", "no overflow on pop+push", overflowPulse, 0);
    // R6 clear overrides push and pop
    step("R6", 1, 8'h99, 0, 1, 1);
    chk("R6", "cleared ready", rxReady, 0);
    chk("R6", "cleared full", fifoFull, 0);
    chk("R6", "readData zero", readData, 8'h00);
    // Random mix against the model
    for (int i = 0; i < 1500; i++) begin
      int r;
      bit psh, brk, pop, clr;
      r   = $urandom_range(0, 99);
      psh = ($urandom_range(0, 99) < 55);
      brk = (r < 6);
      pop = ($urandom_range(0, 99) < 40);
      clr = (r > 97);
      if ($urandom_range(0, 49) == 0) rxEnable = ~rxEnable;
      step("R8", psh, 8'($urandom), brk, pop, clr);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule